// File: doc/BRIEF.md
# Odd/Even Pixel Port Splitter

This block sits between a pixel stream running at the input pixel clock and a column driver that has two input ports. Each pixel is 18 bits, three 6-bit colour fields, and arrives with a data-enable. The block pairs consecutive pixels of a line. The first pixel of each pair goes to the odd bus and the second to the even bus, and both are presented in the same cycle of an output clock that runs at half the input rate.

The block also produces the inverted copy of that output clock and a start pulse that leads each line's first pair by exactly one output clock period. A bus-sequence select swaps the red and blue fields on both buses, for drivers wired in blue-green-red order. The output clock is a register toggling on every input clock edge, so it lives in the input clock domain and needs no PLL. Data and the start pulse change only on the input edges where the output clock falls, so they are stable when it rises.

Top module: `oeSplitTop`

## Requirements
- R1: Within a line, pixels 1, 3, 5, ... appear on `oddBus` and pixels 2, 4, 6, ... appear on `evenBus`. Each odd pixel shares an output cycle with the pixel that follows it. Pairs come out in input order, in consecutive output cycles, with no empty cycle inside a line.
- R2: Each bus is 18 bits: red in bits [17:12], green in bits [11:6], blue in bits [5:0] when the fields are not swapped.
- R3: `outClk` toggles on every input clock edge after reset, so its rate is half the input rate. `outClkN` is always its complement. `oddBus`, `evenBus` and `startPulse` change only on input edges where `outClk` falls.
- R4: `startPulse` is high during the output clock period just before the one that carries the first pair of each line.
- R5: `startPulse` is one output period (two input cycles) wide and is never high except ahead of a line's first pair.
- R6: With `swapRb` at 0 the fields keep the R2 layout. With `swapRb` at 1 the red and blue fields trade places on both buses, giving blue in [17:12] and red in [5:0].
- R7: The first data-enable-high pixel after data-enable has been low is always an odd pixel, so pairing restarts on every line.
- R8: A line with an odd pixel count ends with a pair whose even half is all zeros, and that pair is still emitted.
- R9: In output cycles that carry no pair, both buses are zero.
- R10: While `rstN` is low, both buses and `startPulse` are zero, `outClk` is 0 and `outClkN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock |
| rstN | input | 1 | Synchronous reset, active low |
| pixIn | input | 18 | Input pixel, R2 field layout |
| de | input | 1 | Data enable, high for the active pixels of a line |
| swapRb | input | 1 | Red/blue field swap select |
| oddBus | output | 18 | Odd-pixel output bus |
| evenBus | output | 18 | Even-pixel output bus |
| outClk | output | 1 | Half-rate output clock |
| outClkN | output | 1 | Complement of the output clock |
| startPulse | output | 1 | Line start pulse, one output period ahead of the data |

## Verification
The assertions assume that data-enable stays low for at least one input cycle between lines. That spacing keeps completed pairs at least two input cycles apart, so the single pending slot never has to hold two pairs. They also assume the red/blue select is changed only while no line is in flight. The stimulus sweeps line lengths from one to nine pixels and gaps of one to three cycles, which hits both output clock phases at the start of a line. It never drops data-enable for less than a cycle and changes the swap select only after the pipeline has drained. All pixel values are nonzero, so a pair can be told apart from an idle cycle.

// File: rtl/oeSplitPkg.sv
package oeSplitPkg;

  // Strobes the control hands to the datapath each input cycle.
  typedef struct packed {
    logic capOdd;    // latch the incoming pixel as the odd half
    logic capEven;   // incoming pixel completes the pair as the even half
    logic loadPend;  // completed pair must wait for the next output tick
    logic tick;      // output clock falls at this edge: update the buses
    logic srcValid;  // a pair is available to enter the stage this tick
    logic usePend;   // take that pair from the pending slot, not the live path
  } ctrlStrobes_t;

endpackage

// File: rtl/oeSplitCtrl.sv
module oeSplitCtrl
  import oeSplitPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         de,
  output ctrlStrobes_t strb,
  output logic         outClk,
  output logic         outClkN,
  output logic         startPulse
);

  logic deQ;
  logic haveOdd;
  logic firstOdd;
  logic pendValid;
  logic pendFirst;

  logic deRise;
  logic capOdd;
  logic capEven;
  logic flush;
  logic complete;
  logic tick;
  logic srcValid;
  logic srcFirst;
  logic loadPend;

  always_comb begin
    deRise   = de & ~deQ;
    capOdd   = de & (deRise | ~haveOdd);
    capEven  = de & haveOdd & ~deRise;
    flush    = ~de & haveOdd;
    complete = capEven | flush;
    tick     = outClk;
    srcValid = complete | pendValid;
    srcFirst = complete ? firstOdd : pendFirst;
    loadPend = complete & ~tick;
  end

  always_comb begin
    strb.capOdd   = capOdd;
    strb.capEven  = capEven;
    strb.loadPend = loadPend;
    strb.tick     = tick;
    strb.srcValid = srcValid;
    strb.usePend  = ~complete;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deQ        <= 1'b0;
      haveOdd    <= 1'b0;
      firstOdd   <= 1'b0;
      pendValid  <= 1'b0;
      pendFirst  <= 1'b0;
      outClk     <= 1'b0;
      outClkN    <= 1'b1;
      startPulse <= 1'b0;
    end else begin
      deQ     <= de;
      outClk  <= ~outClk;
      outClkN <= outClk;
      if (capOdd) begin
        haveOdd  <= 1'b1;
        firstOdd <= deRise;
      end else if (complete) begin
        haveOdd <= 1'b0;
      end
      if (loadPend) begin
        pendValid <= 1'b1;
        pendFirst <= firstOdd;
      end else if (tick) begin
        pendValid <= 1'b0;
      end
      if (tick) begin
        startPulse <= srcValid & srcFirst;
      end
    end
  end

  // R1: a completed pair never lands on an occupied pending slot
  a_r1_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (complete && !tick) |-> !pendValid);

  // R5: a rising start pulse holds through the next input cycle
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startPulse) |=> $stable(startPulse));

  // R7: a new line always begins with an odd pixel held
  a_r7_restart_odd: assert property (@(posedge clk) disable iff (!rstN)
    (de && !deQ) |=> haveOdd);

  // R8: an odd pixel left over at the end of a line is flushed
  a_r8_flush: assert property (@(posedge clk) disable iff (!rstN)
    (haveOdd && !de) |=> !haveOdd);

endmodule

// File: rtl/oeSplitData.sv
module oeSplitData
  import oeSplitPkg::*;
#(
  parameter int COLOR_W = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strb,
  input  logic [3*COLOR_W-1:0]   pixIn,
  input  logic                   swapRb,
  output logic [3*COLOR_W-1:0]   oddBus,
  output logic [3*COLOR_W-1:0]   evenBus
);

  localparam int PIX_W = 3 * COLOR_W;

  logic [PIX_W-1:0] oddHold;
  logic [PIX_W-1:0] pendOdd;
  logic [PIX_W-1:0] pendEven;
  logic [PIX_W-1:0] stageOdd;
  logic [PIX_W-1:0] stageEven;
  logic [PIX_W-1:0] newEven;
  logic [PIX_W-1:0] srcOdd;
  logic [PIX_W-1:0] srcEven;
  logic [PIX_W-1:0] outOdd;
  logic [PIX_W-1:0] outEven;

  always_comb begin
    newEven = strb.capEven ? pixIn : '0;
    srcOdd  = strb.usePend ? pendOdd  : oddHold;
    srcEven = strb.usePend ? pendEven : newEven;
  end

  // Field order: generate picks straight or swapped red/blue per field slot.
  for (genvar f = 0; f < 3; f++) begin : g_field
    localparam int SRC_SW = 2 - f;
    always_comb begin
      if (swapRb) begin
        outOdd [f*COLOR_W +: COLOR_W] = stageOdd [SRC_SW*COLOR_W +: COLOR_W];
        outEven[f*COLOR_W +: COLOR_W] = stageEven[SRC_SW*COLOR_W +: COLOR_W];
      end else begin
        outOdd [f*COLOR_W +: COLOR_W] = stageOdd [f*COLOR_W +: COLOR_W];
        outEven[f*COLOR_W +: COLOR_W] = stageEven[f*COLOR_W +: COLOR_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oddHold   <= '0;
      pendOdd   <= '0;
      pendEven  <= '0;
      stageOdd  <= '0;
      stageEven <= '0;
      oddBus    <= '0;
      evenBus   <= '0;
    end else begin
      if (strb.capOdd) begin
        oddHold <= pixIn;
      end
      if (strb.loadPend) begin
        pendOdd  <= oddHold;
        pendEven <= newEven;
      end
      if (strb.tick) begin
        stageOdd  <= strb.srcValid ? srcOdd  : '0;
        stageEven <= strb.srcValid ? srcEven : '0;
        oddBus    <= outOdd;
        evenBus   <= outEven;
      end
    end
  end

  // R3: the buses move only on output ticks
  a_r3_bus_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.tick) |-> ($stable(oddBus) && $stable(evenBus)));

  // R9: an empty tick leaves a zero stage
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.srcValid) |=> (stageOdd == '0 && stageEven == '0));

endmodule

// File: rtl/oeSplitTop.sv
module oeSplitTop
  import oeSplitPkg::*;
#(
  parameter int COLOR_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3*COLOR_W-1:0] pixIn,
  input  logic                 de,
  input  logic                 swapRb,
  output logic [3*COLOR_W-1:0] oddBus,
  output logic [3*COLOR_W-1:0] evenBus,
  output logic                 outClk,
  output logic                 outClkN,
  output logic                 startPulse
);

  ctrlStrobes_t strb;

  oeSplitCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .de         (de),
    .strb       (strb),
    .outClk     (outClk),
    .outClkN    (outClkN),
    .startPulse (startPulse)
  );

  oeSplitData #(.COLOR_W(COLOR_W)) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .pixIn   (pixIn),
    .swapRb  (swapRb),
    .oddBus  (oddBus),
    .evenBus (evenBus)
  );

  // R3: the two output clocks are always complementary
  a_r3_clk_pair: assert property (@(posedge clk) disable iff (!rstN)
    outClkN != outClk);

endmodule

// File: tb/test_oeSplitTop.sv
module test_oeSplitTop;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 18;
  localparam int MAXP = 1024;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [PW-1:0] pixIn = '0;
  logic          de = 1'b0;
  logic          swapRb = 1'b0;
  logic [PW-1:0] oddBus;
  logic [PW-1:0] evenBus;
  logic          outClk;
  logic          outClkN;
  logic          startPulse;

  int nChecks = 0;
  int nFails = 0;
  int pixCount = 0;

  logic [PW-1:0] expOdd [MAXP];
  logic [PW-1:0] expEven [MAXP];
  logic          expFirst [MAXP];
  int wrIdx = 0;
  int rdIdx = 0;

  logic [PW-1:0] lastOdd = '0;
  logic [PW-1:0] lastEven = '0;
  logic          lastStart = 1'b0;
  logic          prevStart = 1'b0;
  logic          prevData = 1'b0;
  logic          monOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oeSplitTop i_oeSplitTop (
    .clk(clk), .rstN(rstN), .pixIn(pixIn), .de(de), .swapRb(swapRb),
    .oddBus(oddBus), .evenBus(evenBus), .outClk(outClk), .outClkN(outClkN),
    .startPulse(startPulse)
  );

  function automatic logic [PW-1:0] pixVal(int k);
    return PW'((k * 2731 + 977) % 262144) | 18'h00040;
  endfunction

  function automatic logic [PW-1:0] swapF(logic [PW-1:0] p, logic s);
    return s ? {p[5:0], p[11:6], p[17:12]} : p;
  endfunction

  task automatic check(logic ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  // Drive one line of n pixels followed by gap idle cycles; expected pairs pushed first.
  task automatic sendLine(int n, int gap);
    for (int i = 0; i < n; i += 2) begin
      expOdd[wrIdx]   = pixVal(pixCount + i);
      expEven[wrIdx]  = (i + 1 < n) ? pixVal(pixCount + i + 1) : '0;
      expFirst[wrIdx] = (i == 0);
      wrIdx++;
    end
    for (int i = 0; i < n; i++) begin
      de = 1'b1;
      pixIn = pixVal(pixCount + i);
      @(negedge clk);
    end
    pixCount += n;
    de = 1'b0;
    pixIn = '0;
    repeat (gap) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (monOn) begin
      logic dataNow;
      check(outClkN == ~outClk, "R3 clock complement", {17'd0, outClkN}, {17'd0, ~outClk});
      if (outClk == 1'b0) begin
        dataNow = (oddBus != '0) || (evenBus != '0);
        if (dataNow) begin
          if (rdIdx >= wrIdx) begin
            check(1'b0, "R9 data with nothing pending", oddBus, '0);
          end else begin
            check(oddBus == swapF(expOdd[rdIdx], swapRb),
                  swapRb ? "R6 odd swapped" : "R1 R2 odd bus", oddBus, swapF(expOdd[rdIdx], swapRb));
            check(evenBus == swapF(expEven[rdIdx], swapRb),
                  (expEven[rdIdx] == '0) ? "R8 zero fill" : (swapRb ? "R6 even swapped" : "R1 R2 even bus"),
                  evenBus, swapF(expEven[rdIdx], swapRb));
            if (expFirst[rdIdx])
              check(prevStart, "R4 R7 pulse before first pair", {17'd0, prevStart}, 18'd1);
            else
              check(prevData, "R1 contiguous pairs", {17'd0, prevData}, 18'd1);
            rdIdx++;
          end
        end else if (rdIdx < wrIdx && !expFirst[rdIdx] && prevData) begin
          check(1'b0, "R1 gap inside line", '0, expOdd[rdIdx]);
        end
        if (startPulse)
          check(rdIdx < wrIdx && expFirst[rdIdx], "R5 spurious start pulse", {17'd0, startPulse}, '0);
        prevStart = startPulse;
        prevData  = dataNow;
      end else begin
        check(oddBus == lastOdd && evenBus == lastEven, "R3 buses hold off tick", oddBus, lastOdd);
        check(startPulse == lastStart, "R5 pulse width", {17'd0, startPulse}, {17'd0, lastStart});
      end
      lastOdd   = oddBus;
      lastEven  = evenBus;
      lastStart = startPulse;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    check(oddBus == '0 && evenBus == '0, "R10 buses in reset", oddBus | evenBus, '0);
    check(startPulse == 1'b0 && outClk == 1'b0 && outClkN == 1'b1, "R10 clocks and pulse in reset",
          {15'd0, startPulse, outClk, outClkN}, 18'd1);
    de = 1'b1;
    pixIn = 18'h3FFFF;
    @(negedge clk);
    check(oddBus == '0 && startPulse == 1'b0, "R10 input ignored in reset", oddBus, '0);
    de = 1'b0;
    pixIn = '0;
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;
    repeat (4) @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      swapRb = s[0];
      repeat (2) @(negedge clk);
      for (int n = 1; n <= 9; n++) begin
        for (int g = 1; g <= 3; g++) begin
          sendLine(n, g);
        end
      end
      repeat (12) @(negedge clk);
    end
    // back-to-back single-pixel lines with the shortest gap
    for (int i = 0; i < 6; i++) sendLine(1, 1);
    repeat (12) @(negedge clk);
    check(rdIdx == wrIdx, "R1 every pair emitted", PW'(rdIdx), PW'(wrIdx));
    check(oddBus == '0 && evenBus == '0 && startPulse == 1'b0, "R9 idle after drain", oddBus | evenBus, '0);
    monOn = 1'b0;
    summary();
    $finish;
  end

endmodule